// File: doc/BRIEF.md
# Byte-strobe read-modify-write bridge

This block joins an upstream APB completer port that carries per-byte write enables to a downstream APB requester port that has none, so every downstream write replaces a whole 32-bit word. A write that enables only some of the four byte lanes is turned into two downstream transfers. The bridge first reads the addressed word, then overlays the enabled bytes of the incoming data and writes the merged word back.

The upstream transfer is held with wait states until the downstream sequence is done. Two strobe patterns take a shortcut. If every lane is enabled, the bridge issues one plain write with no read. If no lane is enabled, it issues no downstream transfer at all.

Upstream reads become one downstream read, and the strobe plays no part in them. Address, data and strobe are captured when the upstream access phase is accepted and are held for the whole sequence.

Top module: `strb_rmw_bridge`

## Requirements
- R1: Strobe bit i (i = 0..3) selects write-data bits [8i+7:8i] for byte i of the downstream word; the mapping is fixed by position.
- R2: A byte whose strobe bit is 0 keeps the value read from downstream; it is never zeroed and never taken from the write data.
- R3: A write whose strobe is neither 4'b0000 nor 4'b1111 produces exactly one downstream read followed by exactly one downstream write of the merged word.
- R4: A write with strobe 4'b1111 produces exactly one downstream write of the upstream data and no downstream read.
- R5: A write with strobe 4'b0000 produces no downstream transfer; up_ready rises in the cycle after the access phase is accepted, and the downstream word is unchanged.
- R6: An upstream read (up_write = 0) produces exactly one downstream read and no write, and returns the full downstream word whatever the strobe value.
- R7: Sparse patterns such as 4'b0101, 4'b1010 and 4'b1001 are merged lane by lane exactly like contiguous ones.
- R8: up_ready stays low while any downstream transfer is in flight and is high for exactly one cycle per upstream transfer. With dn_ready always high, the cycles from acceptance to up_ready are: 1 for an empty strobe, 3 for a full write or a read, and 5 for a partial write.
- R9: Each downstream transfer has a setup cycle (dn_sel = 1, dn_enable = 0) followed by access cycles. While dn_ready is low in an access cycle, dn_addr, dn_write and dn_wdata hold steady.
- R10: Every downstream transfer of a sequence uses the captured upstream address.
- R11: While rst is high, and in the first cycle after it, dn_sel, dn_enable and up_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_sel | input | 1 | Upstream select |
| up_enable | input | 1 | Upstream access-phase flag |
| up_write | input | 1 | Upstream direction, 1 = write |
| up_addr | input | AW | Upstream byte address |
| up_wdata | input | DW | Upstream write data |
| up_strb | input | DW/8 | Upstream per-byte write enables |
| up_rdata | output | DW | Upstream read data, valid with up_ready |
| up_ready | output | 1 | Upstream transfer completion |
| dn_sel | output | 1 | Downstream select |
| dn_enable | output | 1 | Downstream access-phase flag |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | AW | Downstream byte address |
| dn_wdata | output | DW | Downstream full-word write data |
| dn_rdata | input | DW | Downstream read data |
| dn_ready | input | 1 | Downstream transfer completion |

## Verification
The assertions assume that the upstream requester obeys APB. It keeps up_sel, up_addr, up_write, up_wdata and up_strb steady from setup until up_ready, and it drops up_enable in the cycle after up_ready. The address check in particular compares the downstream address against the live upstream address.

The bench's upstream driver follows that discipline in every transfer. The downstream completer model inserts random wait states, except in a directed phase where dn_ready stays high so that latencies can be counted exactly.

The stimulus covers:
- every single-lane pattern, both halfwords, the sparse patterns, and the empty and full patterns;
- reads issued with non-zero strobes;
- random mixes of the above.

// File: rtl/strb_rmw_pkg.sv
package strb_rmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_ACCESS,
    ST_WR_SETUP,
    ST_WR_ACCESS,
    ST_RESP
  } seq_state_t;

  typedef enum logic [1:0] {
    SC_NONE,
    SC_PART,
    SC_FULL
  } strb_class_t;

endpackage

// File: rtl/strb_class.sv
module strb_class #(
  parameter int NB = 4
) (
  input  logic [NB-1:0]             strb,
  output strb_rmw_pkg::strb_class_t cls
);
  import strb_rmw_pkg::*;

  always_comb begin
    if (&strb)       cls = SC_FULL;
    else if (~|strb) cls = SC_NONE;
    else             cls = SC_PART;
  end

endmodule

// File: rtl/strb_merge.sv
module strb_merge #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] new_word,
  input  logic [NB-1:0] strb,
  output logic [DW-1:0] merged
);

  // each lane picks its own source, independent of the others
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign merged[8*g +: 8] = strb[g] ? new_word[8*g +: 8] : old_word[8*g +: 8];
  end

endmodule

// File: rtl/strb_rmw_bridge.sv
module strb_rmw_bridge #(
  parameter int AW = 12,
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_sel,
  input  logic          up_enable,
  input  logic          up_write,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  input  logic [NB-1:0] up_strb,
  output logic [DW-1:0] up_rdata,
  output logic          up_ready,
  output logic          dn_sel,
  output logic          dn_enable,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic [DW-1:0] dn_rdata,
  input  logic          dn_ready
);
  import strb_rmw_pkg::*;

  seq_state_t  state;
  strb_class_t in_cls;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [NB-1:0] req_strb;
  logic          req_write;
  logic [DW-1:0] wr_word;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] merged_word;
  logic          accept;

  strb_class #(.NB(NB)) u_class (
    .strb (up_strb),
    .cls  (in_cls)
  );

  strb_merge #(.DW(DW)) u_merge (
    .old_word (dn_rdata),
    .new_word (req_wdata),
    .strb     (req_strb),
    .merged   (merged_word)
  );

  assign accept = (state == ST_IDLE) && up_sel && up_enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_addr  <= '0;
      req_wdata <= '0;
      req_strb  <= '0;
      req_write <= 1'b0;
      wr_word   <= '0;
      rd_word   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            req_addr  <= up_addr;
            req_wdata <= up_wdata;
            req_strb  <= up_strb;
            req_write <= up_write;
            if (!up_write) begin
              state <= ST_RD_SETUP;
            end else begin
              case (in_cls)
                SC_NONE: state <= ST_RESP;
                SC_FULL: begin
                  wr_word <= up_wdata;
                  state   <= ST_WR_SETUP;
                end
                default: state <= ST_RD_SETUP;
              endcase
            end
          end
        end
        ST_RD_SETUP:  state <= ST_RD_ACCESS;
        ST_RD_ACCESS: begin
          if (dn_ready) begin
            if (req_write) begin
              wr_word <= merged_word;
              state   <= ST_WR_SETUP;
            end else begin
              rd_word <= dn_rdata;
              state   <= ST_RESP;
            end
          end
        end
        ST_WR_SETUP:  state <= ST_WR_ACCESS;
        ST_WR_ACCESS: if (dn_ready) state <= ST_RESP;
        ST_RESP:      state <= ST_IDLE;
        default:      state <= ST_IDLE;
      endcase
    end
  end

  // outputs decode straight from the state flops
  assign dn_sel    = (state == ST_RD_SETUP) || (state == ST_RD_ACCESS) ||
                     (state == ST_WR_SETUP) || (state == ST_WR_ACCESS);
  assign dn_enable = (state == ST_RD_ACCESS) || (state == ST_WR_ACCESS);
  assign dn_write  = (state == ST_WR_SETUP) || (state == ST_WR_ACCESS);
  assign dn_addr   = req_addr;
  assign dn_wdata  = wr_word;
  assign up_ready  = (state == ST_RESP);
  assign up_rdata  = rd_word;

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) up_ready |=> !up_ready); // R8
  AST_NO_READY_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst) dn_sel |-> !up_ready); // R8
  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (rst) (accept && up_write && (up_strb == '0)) |=> (up_ready && !dn_sel)); // R5
  AST_FULL_DIRECT: assert property (@(posedge clk) disable iff (rst) (accept && up_write && (&up_strb)) |=> (dn_sel && dn_write && !dn_enable)); // R4
  AST_PART_READ_FIRST: assert property (@(posedge clk) disable iff (rst) (accept && up_write && (up_strb != '0) && !(&up_strb)) |=> (dn_sel && !dn_write)); // R3
  AST_READ_FWD: assert property (@(posedge clk) disable iff (rst) (accept && !up_write) |=> (dn_sel && !dn_write)); // R6
  AST_DN_SETUP_ACCESS: assert property (@(posedge clk) disable iff (rst) (dn_sel && !dn_enable) |=> (dn_sel && dn_enable)); // R9
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst) (dn_enable && !dn_ready) |=> (dn_enable && $stable(dn_write) && $stable(dn_addr) && $stable(dn_wdata))); // R9
  AST_DN_ADDR: assert property (@(posedge clk) disable iff (rst) dn_sel |-> (dn_addr == up_addr)); // R10
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!dn_sel && !dn_enable && !up_ready)); // R11

endmodule

// File: tb/strb_rmw_bridge_tb_top.sv
`timescale 1ns/1ps
module strb_rmw_bridge_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          up_sel = 1'b0, up_enable = 1'b0, up_write = 1'b0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic [NB-1:0] up_strb = '0;
  logic [DW-1:0] up_rdata;
  logic          up_ready;
  logic          dn_sel, dn_enable, dn_write;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic [DW-1:0] dn_rdata;
  logic          dn_ready = 1'b1;

  always #2 clk = ~clk;

  strb_rmw_bridge #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst),
    .up_sel(up_sel), .up_enable(up_enable), .up_write(up_write),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_strb(up_strb),
    .up_rdata(up_rdata), .up_ready(up_ready),
    .dn_sel(dn_sel), .dn_enable(dn_enable), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
    .dn_ready(dn_ready)
  );

  // downstream completer model: 16 words, no strobes
  logic [DW-1:0] mem [16];
  logic [DW-1:0] exp_mem [16];
  bit fast_mode = 1'b1;
  int tot_rd = 0, tot_wr = 0, tot_addr_bad = 0;
  bit prev_was_wr = 1'b0, last_was_wr = 1'b0;
  logic [AW-1:0] cur_addr = '0;

  assign dn_rdata = mem[dn_addr[5:2]];

  always @(negedge clk) dn_ready <= fast_mode ? 1'b1 : ($urandom_range(0, 2) != 0);

  always @(posedge clk) begin
    if (!rst && dn_sel && dn_enable && dn_ready) begin
      if (dn_write) begin
        mem[dn_addr[5:2]] <= dn_wdata;
        tot_wr <= tot_wr + 1;
      end else begin
        tot_rd <= tot_rd + 1;
      end
      prev_was_wr <= last_was_wr;
      last_was_wr <= dn_write;
      if (dn_addr != cur_addr) tot_addr_bad <= tot_addr_bad + 1;
    end
  end

  int nchk = 0, nbad = 0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] overlay(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                            input logic [NB-1:0] s);
    logic [DW-1:0] r = old_w;
    for (int b = 0; b < NB; b++) if (s[b]) r[8*b +: 8] = new_w[8*b +: 8];
    return r;
  endfunction

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NB-1:0] s, output logic [DW-1:0] rd, output int waits);
    @(negedge clk);
    cur_addr = a;
    up_sel = 1'b1; up_enable = 1'b0; up_write = wr; up_addr = a; up_wdata = d; up_strb = s;
    @(negedge clk);
    up_enable = 1'b1;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!up_ready && waits < 1000);
    rd = up_rdata;
    @(negedge clk);
    up_sel = 1'b0; up_enable = 1'b0;
    check("R8 ready single cycle", {31'd0, up_ready}, 32'd0);
  endtask

  task automatic run_one(input bit wr, input int idx, input logic [DW-1:0] d,
                         input logic [NB-1:0] s, input bit chk_lat);
    logic [DW-1:0] rd, expw;
    int waits, rd0, wr0, bad0, exp_lat;
    string tag;
    rd0 = tot_rd; wr0 = tot_wr; bad0 = tot_addr_bad;
    xfer(wr, AW'(idx << 2), d, s, rd, waits);
    check("R10 downstream address", 32'(tot_addr_bad - bad0), 32'd0);
    if (!wr) begin
      check("R6 read data", rd, exp_mem[idx]);
      check("R6 read count", 32'(tot_rd - rd0), 32'd1);
      check("R6 no write on read", 32'(tot_wr - wr0), 32'd0);
      exp_lat = 3;
    end else begin
      expw = overlay(exp_mem[idx], d, s);
      exp_mem[idx] = expw;
      if (s == 4'b0000) begin
        tag = "R5"; exp_lat = 1;
        check("R5 no read", 32'(tot_rd - rd0), 32'd0);
        check("R5 no write", 32'(tot_wr - wr0), 32'd0);
      end else if (s == 4'b1111) begin
        tag = "R4"; exp_lat = 3;
        check("R4 no read", 32'(tot_rd - rd0), 32'd0);
        check("R4 one write", 32'(tot_wr - wr0), 32'd1);
      end else begin
        tag = (s == 4'b0101 || s == 4'b1010 || s == 4'b1001) ? "R7" : "R3";
        exp_lat = 5;
        check("R3 one read", 32'(tot_rd - rd0), 32'd1);
        check("R3 one write", 32'(tot_wr - wr0), 32'd1);
        check("R3 read then write", {30'd0, prev_was_wr, last_was_wr}, 32'd1);
      end
      check({tag, " R1 R2 merged word"}, mem[idx], expw);
    end
    if (chk_lat) check("R8 latency", 32'(waits), 32'(exp_lat));
  endtask

  initial begin
    int seed_v;
    logic [DW-1:0] tmp;
    seed_v = $urandom(32'h5EED);
    for (int i = 0; i < 16; i++) begin
      tmp = $urandom;
      mem[i] = tmp;
      exp_mem[i] = tmp;
    end
    repeat (3) @(negedge clk);
    check("R11 reset dn_sel", {31'd0, dn_sel}, 32'd0);
    check("R11 reset dn_enable", {31'd0, dn_enable}, 32'd0);
    check("R11 reset up_ready", {31'd0, up_ready}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 after reset idle", {30'd0, dn_sel, up_ready}, 32'd0);

    // directed, zero-wait downstream: exact latencies
    fast_mode = 1'b1;
    run_one(1'b1, 1, 32'hA1B2C3D4, 4'b0001, 1'b1);
    run_one(1'b1, 1, 32'h11223344, 4'b0010, 1'b1);
    run_one(1'b1, 1, 32'h55667788, 4'b0100, 1'b1);
    run_one(1'b1, 1, 32'h99AABBCC, 4'b1000, 1'b1);
    run_one(1'b1, 2, 32'hDEADBEEF, 4'b0011, 1'b1);
    run_one(1'b1, 2, 32'hCAFEF00D, 4'b1100, 1'b1);
    run_one(1'b1, 3, 32'h0F0F0F0F, 4'b0101, 1'b1);
    run_one(1'b1, 3, 32'hF0F0F0F0, 4'b1010, 1'b1);
    run_one(1'b1, 4, 32'h12345678, 4'b1001, 1'b1);
    run_one(1'b1, 5, 32'hFFFFFFFF, 4'b0000, 1'b1);
    run_one(1'b1, 6, 32'h87654321, 4'b1111, 1'b1);
    run_one(1'b0, 6, 32'h0, 4'b1111, 1'b1);
    run_one(1'b0, 3, 32'h0, 4'b0110, 1'b1);
    run_one(1'b0, 5, 32'h0, 4'b0000, 1'b1);

    // random mix with downstream wait states
    fast_mode = 1'b0;
    for (int n = 0; n < 400; n++) begin
      logic [NB-1:0] s;
      int k;
      k = $urandom_range(0, 9);
      s = (k == 0) ? 4'b0000 : (k == 1) ? 4'b1111 : NB'($urandom);
      run_one($urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom, s, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule